// File: doc/BRIEF.md
# Delay-Address Program Port

This block is the programming front end of a programmable delay line. It produces the delay-tap address that the line uses, plus a one-cycle strobe whenever that address changes. Two programming paths are offered, chosen by a mode input. In parallel mode the address bus is passed through while the enable input is high. When enable falls, the last value is frozen. A single enable pulse therefore acts as a latched load, and holding enable high gives transparent control. In serial mode a shift register takes one bit per rising serial-clock edge, most significant bit first, but only while enable is high. The value becomes the active address when enable falls.

The serial path also reads back the current setting. When enable rises, the most significant bit of the current address appears on the serial output. Each shift then moves the next lower old bit out. The read-back is destructive: a host that wants to keep the setting must shift the same bits back in before it lowers enable. Because the serial output follows the register contents, several units can be chained output-to-input. The serial output's drive enable is active only in serial mode while enable is high. All pins are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and enable and serial clock are edge-detected in the system clock domain.

Top module: `dly_addr_prog`

## Requirements
- R1: After reset the address is 0, the update strobe is low and the serial output enable is low.
- R2: With mode = 1 (parallel) and enable high, the address follows the parallel bus. A bus change appears on the address in the third system clock cycle after it is applied.
- R3: With mode = 1 and enable low, the address keeps the value it had when enable fell, and parallel bus changes have no effect.
- R4: With mode = 0 (serial) and enable high, each rising serial-clock edge shifts the serial data bit into bit 0 of the register. After that edge, the serial output shows the next lower bit of the old contents.
- R5: In serial mode, once enable rises and before any serial-clock edge, the serial output shows bit 7 (MSB) of the active address, and its output enable is high.
- R6: In serial mode the active address does not change while bits are being shifted. The falling edge of enable makes the register contents the active address.
- R7: After k shifts (k < 8) and a falling enable, the new address is the old address shifted left by k bits, with the k new bits in the low positions. Shifting the old 8 bits back in restores the old address.
- R8: Serial-clock edges that occur while enable is low leave the register unchanged.
- R9: The serial output enable is low whenever enable is low or mode = 1.
- R10: The update strobe is high for exactly one cycle each time the address changes. It stays low when a committed value equals the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = parallel programming, 0 = serial programming |
| en_i | input | 1 | Enable (asynchronous) |
| par_i | input | ADDR_W | Parallel address bus (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, MSB of the shift register |
| sdo_oe_o | output | 1 | Drive enable for sdo_o |
| addr_o | output | ADDR_W | Active delay address |
| upd_o | output | 1 | One-cycle strobe on address change |

## Verification
If the shift register differs from the active address while enable is low, the first read-back after enable rises shows a wrong MSB within three cycles. A wrong register bit also appears on sdo_o by the eighth serial-clock edge. A spurious or missed shift changes the value committed at the falling enable edge. That shows up on addr_o and as an unexpected or missing update strobe three cycles after enable falls. A stuck strobe or a silent address change is seen in the cycle where the two disagree.

// File: rtl/dap_pkg.sv
package dap_pkg;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/dap_sync.sv
module dap_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dap_edge.sv
module dap_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= d_i;

  assign rise_o = d_i & ~prev_o;
  assign fall_o = ~d_i & prev_o;
endmodule

// File: rtl/dap_shreg.sv
module dap_shreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      q_o <= '0;
    else if (shift_i) q_o <= {q_o[W-2:0], sdi_i};
    else if (load_i)  q_o <= load_val_i;
endmodule

// File: rtl/dap_commit.sv
module dap_commit #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         follow_i,
  input  logic [W-1:0] follow_val_i,
  input  logic         commit_i,
  input  logic [W-1:0] commit_val_i,
  output logic [W-1:0] addr_o,
  output logic         upd_o
);
  logic [W-1:0] addr_d;

  always_comb begin
    addr_d = addr_o;
    if (follow_i)      addr_d = follow_val_i;
    else if (commit_i) addr_d = commit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      addr_o <= '0;
      upd_o  <= 1'b0;
    end else begin
      addr_o <= addr_d;
      upd_o  <= (addr_d != addr_o);
    end
endmodule

// File: rtl/dly_addr_prog.sv
module dly_addr_prog
  import dap_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] par_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              upd_o
);
  localparam int unsigned SYNC_W = ADDR_W + 4;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              mode_s, en_s, sclk_s, sdi_s;
  logic [ADDR_W-1:0] par_s;
  prog_mode_e        mode_e;

  assign raw_bus = {mode_i, en_i, sclk_i, sdi_i, par_i};

  dap_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  assign {mode_s, en_s, sclk_s, sdi_s, par_s} = sync_bus;
  assign mode_e = prog_mode_e'(mode_s);

  // bit 1: enable, bit 0: serial clock
  logic [1:0] edg_prev, edg_rise, edg_fall;
  logic       en_prev, en_fall, sclk_rise;

  dap_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({en_s, sclk_s}),
    .prev_o(edg_prev),
    .rise_o(edg_rise),
    .fall_o(edg_fall)
  );

  assign en_prev   = edg_prev[1];
  assign en_fall   = edg_fall[1];
  assign sclk_rise = edg_rise[0];

  logic              par_follow, ser_shift, ser_commit;
  logic [ADDR_W-1:0] sr_q;

  assign par_follow = (mode_e == MODE_PARALLEL) && en_s;
  assign ser_shift  = (mode_e == MODE_SERIAL) && en_s && sclk_rise;
  assign ser_commit = (mode_e == MODE_SERIAL) && en_fall;

  // register mirrors the parallel value so read-back starts from the active address
  dap_shreg #(.W(ADDR_W)) u_shreg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (par_follow),
    .load_val_i(par_s),
    .shift_i   (ser_shift),
    .sdi_i     (sdi_s),
    .q_o       (sr_q)
  );

  dap_commit #(.W(ADDR_W)) u_commit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .follow_i    (par_follow),
    .follow_val_i(par_s),
    .commit_i    (ser_commit),
    .commit_val_i(sr_q),
    .addr_o      (addr_o),
    .upd_o       (upd_o)
  );

  assign sdo_o    = sr_q[ADDR_W-1];
  assign sdo_oe_o = en_s && (mode_e == MODE_SERIAL);
endmodule

// File: rtl/dap_chk.sv
module dap_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_s_i,
  input logic         en_s_i,
  input logic         en_prev_i,
  input logic         sclk_rise_i,
  input logic         sdi_s_i,
  input logic [W-1:0] sr_i,
  input logic [W-1:0] addr_i,
  input logic         upd_i,
  input logic         sdo_oe_i
);
  assert_upd_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (addr_i != $past(addr_i)));

  assert_no_silent_change_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |-> $stable(addr_i));

  assert_readback_mirror_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s_i && !en_prev_i) |-> (sr_i == addr_i));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s_i && !en_prev_i) |=> $stable(addr_i));

  assert_sclk_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s_i |=> $stable(sr_i));

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_s_i && en_s_i && sclk_rise_i) |=> (sr_i == {$past(sr_i[W-2:0]), $past(sdi_s_i)}));

  assert_oe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_s_i) |-> !sdo_oe_i);
endmodule

bind dly_addr_prog dap_chk #(.W(ADDR_W)) u_dap_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_s_i   (mode_s),
  .en_s_i     (en_s),
  .en_prev_i  (en_prev),
  .sclk_rise_i(sclk_rise),
  .sdi_s_i    (sdi_s),
  .sr_i       (sr_q),
  .addr_i     (addr_o),
  .upd_i      (upd_o),
  .sdo_oe_i   (sdo_oe_o)
);

// File: tb/tb_dly_addr_prog.sv
module tb_dly_addr_prog;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0, en_i = 1'b0, sclk_i = 1'b0, sdi_i = 1'b0;
  logic [W-1:0] par_i = '0;
  logic         sdo_o, sdo_oe_o, upd_o;
  logic [W-1:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];

  always #4 clk = ~clk;

  dly_addr_prog #(.ADDR_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .en_i(en_i), .par_i(par_i),
    .sclk_i(sclk_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
    .addr_o(addr_o), .upd_o(upd_o)
  );

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every update strobe must match the next expected address (R10)
  always @(negedge clk) begin
    if (rst_ni && upd_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: unexpected update, addr %h expected none", addr_o);
      end else begin
        chk("R10 strobe value", addr_o, exp_q.pop_front());
      end
    end
  end

  // one serial bit; checks sdo shows the expected old bit before the edge
  task automatic shift_bit(input logic b, input logic exp_sdo, input string req);
    sdi_i = b;
    clks(3);
    chk(req, {7'b0, sdo_o}, {7'b0, exp_sdo});
    sclk_i = 1'b1;
    clks(4);
    sclk_i = 1'b0;
    clks(3);
  endtask

  initial begin
    clks(5);
    rst_ni = 1'b1;
    clks(2);
    chk("R1 addr", addr_o, 8'h00);
    chk("R1 upd", {7'b0, upd_o}, 8'h00);
    chk("R1 oe", {7'b0, sdo_oe_o}, 8'h00);

    // parallel transparent
    mode_i = 1'b1; par_i = 8'hA5; exp_q.push_back(8'hA5);
    en_i = 1'b1;
    clks(5);
    chk("R2 follow A5", addr_o, 8'hA5);
    chk("R9 oe parallel", {7'b0, sdo_oe_o}, 8'h00);
    par_i = 8'h3C; exp_q.push_back(8'h3C);
    clks(2);
    chk("R2 latency", addr_o, 8'hA5);
    clks(1);
    chk("R2 follow 3C", addr_o, 8'h3C);

    // latched hold
    en_i = 1'b0;
    clks(5);
    par_i = 8'hFF;
    clks(5);
    chk("R3 hold", addr_o, 8'h3C);

    // serial write 0x96, reading back 0x3C
    mode_i = 1'b0;
    clks(5);
    en_i = 1'b1;
    clks(4);
    chk("R5 oe", {7'b0, sdo_oe_o}, 8'h01);
    for (int i = 7; i >= 0; i--) begin
      logic [W-1:0] nv;
      logic [W-1:0] ov;
      nv = 8'h96; ov = 8'h3C;
      shift_bit(nv[i], ov[i], (i == 7) ? "R5 msb first" : "R4 shift out");
    end
    chk("R6 no change before fall", addr_o, 8'h3C);
    exp_q.push_back(8'h96);
    en_i = 1'b0;
    clks(5);
    chk("R6 commit", addr_o, 8'h96);
    chk("R9 oe off", {7'b0, sdo_oe_o}, 8'h00);

    // sclk ignored while enable low
    sdi_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sclk_i = 1'b1; clks(4); sclk_i = 1'b0; clks(4);
    end
    en_i = 1'b1;
    clks(4);
    for (int i = 7; i >= 0; i--) begin
      logic [W-1:0] v;
      v = 8'h96;
      shift_bit(v[i], v[i], "R8 register untouched");
    end
    en_i = 1'b0;
    clks(6);
    chk("R7 restore", addr_o, 8'h96);

    // partial shift: 4 bits 1010 -> 0x6A
    en_i = 1'b1;
    clks(4);
    shift_bit(1'b1, 1'b1, "R7 partial");
    shift_bit(1'b0, 1'b0, "R7 partial");
    shift_bit(1'b1, 1'b0, "R7 partial");
    shift_bit(1'b0, 1'b1, "R7 partial");
    exp_q.push_back(8'h6A);
    en_i = 1'b0;
    clks(5);
    chk("R7 partial commit", addr_o, 8'h6A);

    // back to parallel, clear
    mode_i = 1'b1; par_i = 8'h00;
    clks(5);
    chk("R3 mode switch idle", addr_o, 8'h6A);
    exp_q.push_back(8'h00);
    en_i = 1'b1;
    clks(5);
    en_i = 1'b0;
    clks(5);
    chk("R2 final", addr_o, 8'h00);
    chk("R10 queue drained", W'(exp_q.size()), 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule